// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 16-bit virtual address into a physical address through a small table of segments. The top two address bits pick one of four table entries. The remaining fourteen bits are the offset inside that segment. Each entry holds a physical base and a length. A request that falls inside the selected segment returns base plus offset. A request at or past the segment's length, or into an entry whose length is zero, returns a fault instead.

The table is loaded through a write port. That port only acts while the supervisor input is high, so unprivileged code cannot change its own mapping. After reset every entry is empty, and every access faults until privileged software programs the table. A typical layout places code, data and stack in separate entries and leaves one entry empty as a hole. Translation takes one clock: a request presented on one edge is answered on the outputs after that edge.

Top module: `seg_xlate`

## Requirements
- R1: Reset (rst_n low) clears every entry to base 0 and length 0 and drives rsp_valid, rsp_paddr and rsp_fault to 0; after reset, every request faults until its entry is written.
- R2: Bits [15:14] of req_vaddr select the entry and bits [13:0] form the offset.
- R3: For an in-range request, rsp_paddr equals the entry base plus the offset, modulo 2^16.
- R4: A request whose offset is greater than or equal to the entry length sets rsp_fault and drives rsp_paddr to 0; offset = length-1 is still in range.
- R5: An entry of length 0 is a hole, and every offset in it faults.
- R6: A write with wr_en high and supervisor low leaves the table unchanged.
- R7: A supervisor write loads wr_base and wr_size into entry wr_seg at the clock edge; a request in the same cycle as the write is translated with the entry's old contents.
- R8: rsp_valid is req_valid delayed by one clock; while rsp_valid is low, rsp_paddr and rsp_fault are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | High while the privileged mode is active; gates table writes |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | 2 | Entry to write |
| wr_base | input | 16 | Physical base for the written entry |
| wr_size | input | 15 | Segment length in bytes, 0 to 0x4000 |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault or when idle |
| rsp_fault | output | 1 | Offset outside the segment, or the entry is a hole |

## Verification
The embedded properties assume that rst_n is held low across at least one rising edge before any traffic, and that every control input is at a known level at each edge. They also assume that wr_size never exceeds 0x4000, since the hole and range checks reason about lengths inside one offset span. The bench drives all inputs on falling edges and holds reset low for several cycles. Its write lengths stay within that span, including the full 0x4000 case.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W  = 16,
  parameter int SEG_W = 2,
  parameter int PA_W  = 16,
  localparam int OFF_W = VA_W - SEG_W,
  localparam int NSEG  = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supervisor,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W:0]   wr_size,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);

  logic [NSEG-1:0][PA_W-1:0] base_q;
  logic [NSEG-1:0][OFF_W:0]  size_q;

  wire [SEG_W-1:0] seg  = req_vaddr[VA_W-1 -: SEG_W];
  wire [OFF_W-1:0] off  = req_vaddr[OFF_W-1:0];
  wire [PA_W-1:0]  sel_base = base_q[seg];
  wire [OFF_W:0]   sel_size = size_q[seg];
  wire             out_of_range = {1'b0, off} >= sel_size;
  wire [PA_W-1:0]  sum = sel_base + PA_W'(off);
  wire             wr_ok = wr_en && supervisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (wr_ok) begin
      base_q[wr_seg] <= wr_base;
      size_q[wr_seg] <= wr_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && out_of_range;
      rsp_paddr <= (req_valid && !out_of_range) ? sum : '0;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (size_q == '0 && base_q == '0));

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && rsp_valid));

  assert_hole_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size_q[req_vaddr[VA_W-1 -: SEG_W]] == '0) |=> rsp_fault);

  assert_user_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !supervisor) |=> ($stable(base_q) && $stable(size_q)));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supervisor = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_seg = '0;
  logic [15:0] wr_base = '0;
  logic [14:0] wr_size = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .wr_en(wr_en),
    .wr_seg(wr_seg), .wr_base(wr_base), .wr_size(wr_size),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  always #10 clk = ~clk;

  int m_base [4];
  int m_size [4];
  int vectors = 0;
  int fails = 0;
  bit   e_valid = 0, e_fault = 0;
  int   e_paddr = 0;
  string tag = "R1";
  string e_tag = "R1";
  bit done = 0;

  task automatic compare();
    vectors++;
    if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_paddr !== 16'(e_paddr)) begin
      fails++;
      $display("FAIL %s: got valid=%0b fault=%0b paddr=%h, expected valid=%0b fault=%0b paddr=%h",
               e_tag, rsp_valid, rsp_fault, rsp_paddr, e_valid, e_fault, 16'(e_paddr));
    end
  endtask

  task automatic cyc(input bit rv, input int va, input bit we, input bit sup,
                     input int ws, input int wb, input int wsz);
    int s, o;
    @(negedge clk);
    compare();
    req_valid = rv; req_vaddr = 16'(va);
    wr_en = we; supervisor = sup; wr_seg = 2'(ws); wr_base = 16'(wb); wr_size = 15'(wsz);
    s = (va >> 14) & 3;
    o = va & 16'h3fff;
    e_tag = tag;
    e_valid = rv;
    e_fault = rv && (o >= m_size[s]);
    e_paddr = (rv && !e_fault) ? ((m_base[s] + o) & 16'hffff) : 0;
    if (we && sup) begin m_base[ws] = wb; m_size[ws] = wsz; end
  endtask

  task automatic rd(input int va);
    cyc(1, va, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input bit sup, input int ws, input int wb, input int wsz);
    cyc(0, 0, 1, sup, ws, wb, wsz);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_size[i] = 0; end
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    // R1: empty table faults everywhere
    rd(16'h0000); rd(16'h4123); rd(16'h8000); rd(16'hffff);
    cyc(0, 0, 0, 0, 0, 0, 0);
    // R7: program the example map
    tag = "R7";
    wr(1, 0, 16'h4000, 15'h0700);
    wr(1, 1, 16'h0000, 15'h0500);
    wr(1, 3, 16'h2000, 15'h1000);
    // R2 / R3: in-range translations
    tag = "R3";
    rd(16'h0000); rd(16'h0123); rd(16'h4010); rd(16'hc000); rd(16'hcabc);
    tag = "R2";
    rd(16'h44ff); rd(16'h0005); rd(16'hc005); rd(16'h4005);
    // R4: boundaries
    tag = "R4";
    rd(16'h06ff); rd(16'h0700); rd(16'h44ff); rd(16'h4500);
    rd(16'hcfff); rd(16'hd000); rd(16'h3fff);
    // R5: hole at segment 2
    tag = "R5";
    rd(16'h8000); rd(16'h8001); rd(16'hbfff);
    // R6: user-mode writes ignored
    tag = "R6";
    wr(0, 0, 16'h1234, 15'h4000);
    wr(0, 2, 16'h5000, 15'h0100);
    rd(16'h0700); rd(16'h8000); rd(16'h0010);
    // R7: same-cycle write sees old entry, next sees new
    tag = "R7";
    cyc(1, 16'h8010, 1, 1, 2, 16'h6000, 15'h0100);
    rd(16'h8010); rd(16'h80ff); rd(16'h8100);
    // R3: full-length segment and address wrap
    tag = "R3";
    wr(1, 1, 16'hf000, 15'h4000);
    rd(16'h7fff); rd(16'h4000); rd(16'h5000);
    // R8: idle gaps and back-to-back
    tag = "R8";
    cyc(0, 16'h4001, 0, 0, 0, 0, 0);
    rd(16'h4001); cyc(0, 16'hffff, 0, 0, 0, 0, 0); rd(16'h0001); rd(16'h0002);
    // mixed traffic
    tag = "R3";
    for (int k = 0; k < 300; k++) begin
      if (k % 37 == 0)
        cyc($urandom_range(0, 1), $urandom_range(0, 65535), 1, $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 65535), $urandom_range(0, 16384));
      else
        cyc($urandom_range(0, 3) != 0, $urandom_range(0, 65535), 0, 0, 0, 0, 0);
    end
    // R1: reset mid-run clears table
    tag = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_size[i] = 0; end
    e_valid = 0; e_fault = 0; e_paddr = 0;
    req_valid = 0; wr_en = 0;
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    rd(16'h0000); rd(16'hc000);
    cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule